// File: doc/BRIEF.md
# Genome-Configured Logic Array

This block is a small evolvable logic fabric. A wide configuration word, the genome, sets both the wiring and the logic function of every cell in a grid of six layers with eight functional units each. Every unit picks three signals from the layer in front of it, can flip each one, and combines them with one of four functions: pass-through, two-way select, three-input AND or three-input XOR. Each layer ends in a register, so a vector moves one layer per clock and a new vector can enter on every cycle.

A search engine outside the block writes a candidate genome, streams test vectors through the array and scores the results. The block only holds the genome and evaluates vectors. A new genome is taken only when no vector is in the array, so a result never mixes two configurations. The array result is the lowest four units of the last layer.

Top module: `gcla_array`

## Requirements
- R1: Reset is synchronous and active low. While it is applied, and at its release, out_valid is 0, out_data is 0 and the genome is all zeros. With the all-zero genome every output bit copies in_data[0].
- R2: The 14-bit gene of unit u in layer l sits at genome bits [(l*8+u)*14 +: 14]. Input field k (k = 0, 1, 2) occupies gene bits [4k+3:4k], where bit 4k+3 is the invert flag and bits [4k+2:4k] are the source index. The function code is gene bits [13:12].
- R3: In layer 0, source indices 0 to 3 choose in_data[0] to in_data[3], and indices 4 to 7 choose the complements of in_data[0] to in_data[3].
- R4: In layers 1 to 5, source index j chooses the registered output of unit j in the previous layer.
- R5: A set invert flag complements the selected source before the function uses it.
- R6: Function codes: 0 passes input 0 through. 1 is a select that gives input 2 when input 0 is 1 and input 1 otherwise. 2 is the AND of all three inputs. 3 is the XOR of all three inputs.
- R7: out_valid rises exactly 6 rising edges after the edge that samples in_valid high, and never earlier. Vectors sent on consecutive cycles come out on consecutive cycles, in the same order.
- R8: out_data[i] is the output of unit i in the final layer, for i = 0 to 3.
- R9: When genome_load is 1, in_valid is 0 and no vector is in the array, genome_data is stored at that edge. Every vector that enters afterwards uses the new genome.
- R10: A genome_load raised while in_valid is 1 or while any vector is in the array is ignored, and the previous genome stays in force.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| genome_load | input | 1 | Request to store genome_data |
| genome_data | input | 672 | Candidate genome |
| in_valid | input | 1 | in_data holds a vector to evaluate |
| in_data | input | 4 | Primary input vector |
| out_valid | output | 1 | out_data holds a result |
| out_data | output | 4 | Low four unit outputs of the final layer |

## Verification
The assertions assume that genome_load, genome_data and in_valid hold known values on every edge after reset, and that the request to load and the stream of vectors come from one source that does not expect a load to be queued. The bench changes all inputs on the falling edge. It raises genome_load alone only after the array has drained, and it sets up collisions between a load and live vectors only in the directed test that checks a load is rejected. Data values are all 16 combinations of the primary inputs, so every select and function path the test genomes build is driven with both polarities.

// File: rtl/gcla_pkg.sv
// Shared sizes and function encoding for the genome-configured logic array.
// Assumes every layer has the same unit count, and that a select field is
// wide enough to index all sources of a layer.
package gcla_pkg;
    localparam int N_IN     = 4;
    localparam int N_OUT    = 4;
    localparam int UNITS    = 8;
    localparam int LAYERS   = 6;
    localparam int FAN_IN   = 3;
    localparam int SEL_W    = $clog2(UNITS);
    localparam int FIELD_W  = SEL_W + 1;
    localparam int FN_W     = 2;
    localparam int GENE_W   = FAN_IN * FIELD_W + FN_W;
    localparam int GENOME_W = LAYERS * UNITS * GENE_W;

    typedef enum logic [FN_W-1:0] {
        FN_BUF = 2'd0,
        FN_MUX = 2'd1,
        FN_AND = 2'd2,
        FN_XOR = 2'd3
    } unit_fn_e;
endpackage

// File: rtl/gcla_unit.sv
// One functional unit. It is purely combinational: three invertible selected
// sources are combined by one of four functions. Assumes SRC_N <= 2**SEL_W.
module gcla_unit
    import gcla_pkg::*;
#(
    parameter int SRC_N = UNITS
) (
    input  logic [SRC_N-1:0]  src,
    input  logic [GENE_W-1:0] gene,
    output logic              y
);
    logic [FAN_IN-1:0] opnd;
    unit_fn_e          fn;

    assign fn = unit_fn_e'(gene[GENE_W-1 -: FN_W]);

    // One selector with a conditional inverter per input field
    for (genvar k = 0; k < FAN_IN; k++) begin : g_field
        logic [SEL_W-1:0] sel;
        logic             inv;
        assign sel     = gene[k*FIELD_W +: SEL_W];
        assign inv     = gene[k*FIELD_W + SEL_W];
        assign opnd[k] = src[sel] ^ inv;
    end

    // Apply the coded function to the three conditioned operands
    always_comb begin
        unique case (fn)
            FN_BUF:  y = opnd[0];
            FN_MUX:  y = opnd[0] ? opnd[2] : opnd[1];
            FN_AND:  y = &opnd;
            FN_XOR:  y = ^opnd;
            default: y = 1'b0;
        endcase
    end
endmodule

// File: rtl/gcla_layer.sv
// One layer of units followed by its output register. Assumes the genes of
// the layer are packed with unit 0 in the lowest GENE_W bits.
module gcla_layer
    import gcla_pkg::*;
#(
    parameter int SRC_N = UNITS,
    parameter int N_U   = UNITS
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [SRC_N-1:0]      src,
    input  logic [N_U*GENE_W-1:0] genes,
    output logic [N_U-1:0]        q
);
    logic [N_U-1:0] d;

    for (genvar u = 0; u < N_U; u++) begin : g_unit
        gcla_unit #(.SRC_N(SRC_N)) unit_i (
            .src  (src),
            .gene (genes[u*GENE_W +: GENE_W]),
            .y    (d[u])
        );
    end

    // Register the layer outputs every cycle
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/gcla_genome_store.sv
// Holds the active genome. It updates only when the load enable, already
// qualified by the caller, is high. Resets to all zeros.
module gcla_genome_store
    import gcla_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load_en,
    input  logic [GENOME_W-1:0] data,
    output logic [GENOME_W-1:0] q
);
    // Capture a new genome on a qualified load
    always_ff @(posedge clk) begin
        if (!rst_n)       q <= '0;
        else if (load_en) q <= data;
    end
endmodule

// File: rtl/gcla_array.sv
// Top of the genome-configured logic array: LAYERS registered layers of
// UNITS units, a valid pipeline that runs alongside the data, and a genome
// store that accepts a load only while nothing is in the array.
// Assumes LAYERS >= 2 and 2*N_IN <= UNITS.
module gcla_array
    import gcla_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                genome_load,
    input  logic [GENOME_W-1:0] genome_data,
    input  logic                in_valid,
    input  logic [N_IN-1:0]     in_data,
    output logic                out_valid,
    output logic [N_OUT-1:0]    out_data
);
    localparam int LAYER_GW = UNITS * GENE_W;

    logic [GENOME_W-1:0] genome_q;
    logic [LAYERS-1:0]   vld_q;
    logic [UNITS-1:0]    src0;
    logic [UNITS-1:0]    lq [LAYERS];
    logic                busy;
    logic                load_en;

    // A load is refused while a vector is entering or in flight
    assign busy    = in_valid | (|vld_q);
    assign load_en = genome_load & ~busy;

    gcla_genome_store store_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_en (load_en),
        .data    (genome_data),
        .q       (genome_q)
    );

    // Layer 0 sources: true inputs, then their complements, then zero fill
    for (genvar j = 0; j < UNITS; j++) begin : g_src0
        if (j < N_IN) begin : g_true
            assign src0[j] = in_data[j];
        end else if (j < 2*N_IN) begin : g_comp
            assign src0[j] = ~in_data[j-N_IN];
        end else begin : g_zero
            assign src0[j] = 1'b0;
        end
    end

    for (genvar l = 0; l < LAYERS; l++) begin : g_layer
        if (l == 0) begin : g_first
            gcla_layer #(.SRC_N(UNITS), .N_U(UNITS)) layer_i (
                .clk   (clk),
                .rst_n (rst_n),
                .src   (src0),
                .genes (genome_q[l*LAYER_GW +: LAYER_GW]),
                .q     (lq[l])
            );
        end else begin : g_next
            gcla_layer #(.SRC_N(UNITS), .N_U(UNITS)) layer_i (
                .clk   (clk),
                .rst_n (rst_n),
                .src   (lq[l-1]),
                .genes (genome_q[l*LAYER_GW +: LAYER_GW]),
                .q     (lq[l])
            );
        end
    end

    // Shift the valid flag one layer per cycle alongside the data
    always_ff @(posedge clk) begin
        if (!rst_n) vld_q <= '0;
        else        vld_q <= {vld_q[LAYERS-2:0], in_valid};
    end

    assign out_valid = vld_q[LAYERS-1];
    assign out_data  = lq[LAYERS-1][N_OUT-1:0];
endmodule

// File: rtl/gcla_array_chk.sv
// Checker for gcla_array. It keeps its own record of the vectors in flight
// and checks latency and genome stability against it.
module gcla_array_chk
    import gcla_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                genome_load,
    input  logic [GENOME_W-1:0] genome_data,
    input  logic                in_valid,
    input  logic                out_valid,
    input  logic [GENOME_W-1:0] genome_q
);
    logic [LAYERS-1:0] shadow_q;

    // Independent record of which cycles carried an input vector
    always_ff @(posedge clk) begin
        if (!rst_n) shadow_q <= '0;
        else        shadow_q <= {shadow_q[LAYERS-2:0], in_valid};
    end

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == shadow_q[LAYERS-1]); // R7

    AST_LOAD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (genome_load && !in_valid && !(|shadow_q)) |=> (genome_q == $past(genome_data))); // R9

    AST_HOLD_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid || (|shadow_q)) |=> $stable(genome_q)); // R10

    AST_HOLD_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        !genome_load |=> $stable(genome_q)); // R9
endmodule

bind gcla_array gcla_array_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .genome_load (genome_load),
    .genome_data (genome_data),
    .in_valid    (in_valid),
    .out_valid   (out_valid),
    .genome_q    (genome_q)
);

// File: tb/gcla_array_tb_top.sv
// Self-checking bench for gcla_array: a table-driven stream under one
// genome, then directed tests for reset, sources, deep-layer functions and
// refused loads.
module gcla_array_tb_top;
    import gcla_pkg::*;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                genome_load = 1'b0;
    logic [GENOME_W-1:0] genome_data = '0;
    logic                in_valid = 1'b0;
    logic [N_IN-1:0]     in_data = '0;
    logic                out_valid;
    logic [N_OUT-1:0]    out_data;

    int n_chk  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    gcla_array dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .genome_load (genome_load),
        .genome_data (genome_data),
        .in_valid    (in_valid),
        .in_data     (in_data),
        .out_valid   (out_valid),
        .out_data    (out_data)
    );

    // Expected results of genome A, indexed by the input vector
    localparam logic [3:0] TBL_A [16] = '{
        4'h8, 4'hD, 4'h9, 4'hC, 4'h1, 4'h4, 4'h0, 4'h5,
        4'h8, 4'h9, 4'hD, 4'hE, 4'h1, 4'h0, 4'h4, 4'h7
    };

    function automatic logic [GENE_W-1:0] mk(input logic i0, input logic [2:0] s0,
                                             input logic i1, input logic [2:0] s1,
                                             input logic i2, input logic [2:0] s2,
                                             input logic [1:0] fn);
        return {fn, i2, s2, i1, s1, i0, s0};
    endfunction

    function automatic int at(input int l, input int u);
        return (l*UNITS + u)*GENE_W;
    endfunction

    // Every unit passes through the same-numbered source
    function automatic logic [GENOME_W-1:0] g_pass();
        logic [GENOME_W-1:0] g = '0;
        for (int l = 0; l < LAYERS; l++)
            for (int u = 0; u < UNITS; u++)
                g[at(l,u) +: GENE_W] = mk(0, 3'(u), 0, 0, 0, 0, 2'd0);
        return g;
    endfunction

    // A: layer 0 functions, double inversion on unit 3 in layers 4 and 5
    function automatic logic [GENOME_W-1:0] g_a();
        logic [GENOME_W-1:0] g = g_pass();
        g[at(0,0) +: GENE_W] = mk(0, 3'd0, 0, 3'd1, 0, 3'd2, 2'd3);
        g[at(0,1) +: GENE_W] = mk(0, 3'd0, 0, 3'd1, 0, 3'd3, 2'd2);
        g[at(0,2) +: GENE_W] = mk(0, 3'd3, 0, 3'd0, 0, 3'd1, 2'd1);
        g[at(0,3) +: GENE_W] = mk(1, 3'd2, 0, 3'd0, 0, 3'd0, 2'd0);
        g[at(4,3) +: GENE_W] = mk(1, 3'd3, 0, 3'd0, 0, 3'd0, 2'd0);
        g[at(5,3) +: GENE_W] = mk(1, 3'd3, 0, 3'd0, 0, 3'd0, 2'd0);
        return g;
    endfunction

    // C: layer 0 takes the complement sources 4..7
    function automatic logic [GENOME_W-1:0] g_c();
        logic [GENOME_W-1:0] g = g_pass();
        for (int u = 0; u < 4; u++)
            g[at(0,u) +: GENE_W] = mk(0, 3'(u+4), 0, 0, 0, 0, 2'd0);
        return g;
    endfunction

    // D: functions and inversions in the final layer
    function automatic logic [GENOME_W-1:0] g_d();
        logic [GENOME_W-1:0] g = g_pass();
        g[at(5,0) +: GENE_W] = mk(0, 3'd0, 0, 3'd1, 0, 3'd2, 2'd2);
        g[at(5,1) +: GENE_W] = mk(0, 3'd0, 0, 3'd1, 1, 3'd3, 2'd3);
        g[at(5,2) +: GENE_W] = mk(0, 3'd7, 0, 3'd2, 0, 3'd3, 2'd1);
        g[at(5,3) +: GENE_W] = mk(1, 3'd4, 0, 3'd0, 0, 3'd0, 2'd0);
        return g;
    endfunction

    function automatic logic [3:0] exp_d(input logic [3:0] v);
        return {v[0], v[3] & v[2], v[0] ^ v[1] ^ ~v[3], v[0] & v[1] & v[2]};
    endfunction

    task automatic check(input string req, input logic [4:0] act, input logic [4:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: valid/data actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic load(input logic [GENOME_W-1:0] g);
        repeat (2) @(negedge clk);
        genome_load = 1'b1;
        genome_data = g;
        @(negedge clk);
        genome_load = 1'b0;
    endtask

    // One vector: no early valid after 5 edges, result after the 6th
    task automatic run_one(input logic [3:0] v, input logic [3:0] exp, input string req);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = v;
        @(negedge clk);
        in_valid = 1'b0;
        repeat (4) @(negedge clk);
        check("R7 early", {out_valid, 4'h0}, 5'b0_0000);
        @(negedge clk);
        check(req, {out_valid, out_data}, {1'b1, exp});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset", {out_valid, out_data}, 5'b0_0000);
        rst_n = 1'b1;

        // R1: all-zero genome copies in_data[0] to every output
        run_one(4'h1, 4'hF, "R1 zero genome");
        run_one(4'hE, 4'h0, "R1 zero genome");

        // R2 R5 R6 R7 R8: back-to-back stream walked from the table
        load(g_a());
        for (int c = 0; c < 22; c++) begin
            @(negedge clk);
            if (c >= 6) check("R2 R6 R8 stream", {out_valid, out_data}, {1'b1, TBL_A[c-6]});
            else        check("R7 latency", {out_valid, 4'h0}, 5'b0_0000);
            in_valid = (c < 16);
            in_data  = 4'(c);
        end
        in_valid = 1'b0;

        // R3: complement sources in layer 0
        load(g_c());
        run_one(4'h5, 4'hA, "R3 complement");
        run_one(4'h0, 4'hF, "R3 complement");

        // R4 R5 R6: functions on previous-layer outputs
        load(g_d());
        for (int v = 0; v < 16; v++)
            run_one(4'(v), exp_d(4'(v)), "R4 R5 R6 deep layer");

        // R10: loads during a live vector are refused
        load(g_a());
        @(negedge clk);
        in_valid    = 1'b1;
        in_data     = 4'h3;
        genome_load = 1'b1;
        genome_data = g_c();
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        genome_load = 1'b0;
        repeat (4) @(negedge clk);
        check("R10 in-flight result", {out_valid, out_data}, {1'b1, TBL_A[3]});
        run_one(4'h0, TBL_A[0], "R10 genome kept");

        // R9: a load on an idle array applies to the next vector
        load(g_c());
        run_one(4'h0, 4'hF, "R9 new genome");

        // R1: reset clears the genome again
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 reset again", {out_valid, out_data}, 5'b0_0000);
        rst_n = 1'b1;
        run_one(4'h1, 4'hF, "R1 genome cleared");

        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule